// File: doc/BRIEF.md
# Port-Input Execution Unit

This unit carries out one already-decoded "read from I/O port into the accumulator" instruction. It receives the opcode byte, an 8-bit immediate, the 16-bit DX register value, the operand-size attribute, the current privilege level (CPL), the I/O privilege level (IOPL), a virtual-8086 mode flag and the current accumulator. From these it derives the port number and the access width. When privilege rules require it, it first reads the task's I/O permission bitmap one byte at a time through a read port. If access is granted, it issues a single read on the I/O bus and merges the returned data into the accumulator. If access is denied, it reports a general-protection fault.

Instructions enter over a valid/ready handshake. `ins_ready` is high only while the unit is idle. An instruction is taken on a rising edge where `ins_valid` and `ins_ready` are both high. `ins_valid` may be held while `ins_ready` is low, and nothing is sampled then. The bitmap port and the I/O bus each use a request/acknowledge pair. The unit holds its request, address and size steady until the matching one-cycle acknowledge arrives, so either side may stall for any number of cycles. Completion is reported by a one-cycle `done`. `fault` is raised together with `done` when the instruction is refused, and `acc_out` carries the result while `done` is high.

Top module: `pio_read_unit`

## Requirements
- R1: Opcode bit 3 picks the port source. When it is 1, the 16-bit DX value is the port. When it is 0, the 8-bit immediate is zero-extended to 16 bits. `io_addr` carries that port.
- R2: Opcode bit 0 picks the width. When it is 0, the access is one byte. When it is 1, operand size 16 (`ins_osize`=0) gives two bytes, and operand size 32 (`ins_osize`=1) or 64 (`ins_osize`=2) gives four bytes. `io_size` encodes the width as 0 for one byte, 1 for two bytes and 2 for four bytes.
- R3: The bitmap is read only when CPL is numerically greater than IOPL, or when `ins_vm` is 1. In every other case no `bm_req` is raised and the bus read follows directly.
- R4: The bitmap check covers ports port through port+width-1, where bit k of the byte at offset j stands for port 8*j+k. The unit reads byte offset port>>3, and then offset (port>>3)+1 only if the covered range crosses into it. Offsets are read in increasing order.
- R5: If any covered bitmap bit is 1, the instruction ends with `fault`, no further bitmap byte is read and no `io_req` is raised.
- R6: If the last needed bitmap offset exceeds `bm_limit`, the instruction ends with `fault` without any bitmap read or bus read.
- R7: A one-byte read replaces only `acc_out[7:0]`. A two-byte read replaces only `acc_out[15:0]`. All other accumulator bits keep their `acc_in` value.
- R8: A four-byte read writes `acc_out[31:0]`. Bits 63:32 become zero when operand size is 64 and keep their `acc_in` value otherwise.
- R9: `done` lasts exactly one cycle per instruction, and `ins_ready` is low from acceptance until `done` has been shown.
- R10: `io_req` and `bm_req`, with their address and size, stay stable until acknowledged, and the two are never high together.
- R11: An opcode other than E4h, E5h, ECh or EDh is accepted and ends with `fault`, with no bitmap or bus read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_valid | input | 1 | Instruction offered |
| ins_ready | output | 1 | Unit idle, instruction will be taken |
| ins_opcode | input | 8 | Opcode byte |
| ins_imm | input | 8 | Immediate port number |
| ins_dx | input | 16 | DX register value |
| ins_osize | input | 2 | Operand size: 0=16, 1=32, 2=64 |
| ins_cpl | input | 2 | Current privilege level |
| ins_iopl | input | 2 | I/O privilege level |
| ins_vm | input | 1 | Virtual-8086 mode |
| acc_in | input | 64 | Accumulator before the instruction |
| bm_limit | input | 14 | Highest legal bitmap byte offset |
| bm_req | output | 1 | Bitmap byte read request |
| bm_addr | output | 14 | Bitmap byte offset |
| bm_ack | input | 1 | Bitmap byte returned |
| bm_data | input | 8 | Bitmap byte |
| io_req | output | 1 | I/O bus read request |
| io_addr | output | 16 | Port number |
| io_size | output | 2 | Access width code |
| io_ack | input | 1 | Bus read completed |
| io_rdata | input | 32 | Bus read data |
| done | output | 1 | Instruction finished (one cycle) |
| fault | output | 1 | General-protection fault, valid with done |
| acc_out | output | 64 | Updated accumulator, valid with done |

## Verification
The first request, either `bm_req` or `io_req`, is due one cycle after the accepting edge. Each later bitmap request appears one cycle after the previous acknowledge. A limit or opcode fault shows `done` one cycle after acceptance, and other instructions show `done` one cycle after the last acknowledge. The bench drives inputs and acknowledges on falling edges and waits for `done` on falling edges. It then compares `fault`, `acc_out` and the request log gathered by its responders at that point. It also confirms that `done` has dropped one cycle later and that `ins_ready` stayed low during the instruction. The bench's responders add a random delay of 0 to 2 cycles before each acknowledge, so both the stall path and the zero-wait path are checked.

// File: rtl/pio_pkg.sv
package pio_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_BMAP = 3'd1,
    ST_BUS  = 3'd2,
    ST_DONE = 3'd3,
    ST_FLT  = 3'd4
  } pio_state_t;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_DWORD = 2'd2
  } io_size_t;

  localparam logic [1:0] OSZ_16 = 2'd0;
  localparam logic [1:0] OSZ_64 = 2'd2;
  localparam logic [7:0] OP_PATTERN = 8'hE4;
  localparam logic [7:0] OP_FIXED_BITS = 8'hF6;
endpackage

// File: rtl/pio_decode.sv
module pio_decode
  import pio_pkg::*;
#(
  parameter int PORT_W = 16,
  parameter int BMO_W = PORT_W - 2
) (
  input  logic [7:0]        opcode,
  input  logic [7:0]        imm,
  input  logic [PORT_W-1:0] dx,
  input  logic [1:0]        osize,
  input  logic [1:0]        cpl,
  input  logic [1:0]        iopl,
  input  logic              vm,
  output logic              bad_op,
  output logic [PORT_W-1:0] port,
  output io_size_t          size,
  output logic              need_chk,
  output logic [BMO_W-1:0]  off_first,
  output logic [BMO_W-1:0]  off_last,
  output logic [7:0]        mask_lo,
  output logic [7:0]        mask_hi,
  output logic              spans_two
);
  logic [3:0]  lane_bits;
  logic [15:0] span;

  always_comb begin
    bad_op   = (opcode & OP_FIXED_BITS) != OP_PATTERN;
    port     = opcode[3] ? dx : PORT_W'(imm);
    if (!opcode[0])          size = SZ_BYTE;
    else if (osize == OSZ_16) size = SZ_WORD;
    else                      size = SZ_DWORD;
    need_chk = (cpl > iopl) || vm;
    case (size)
      SZ_BYTE: lane_bits = 4'b0001;
      SZ_WORD: lane_bits = 4'b0011;
      default: lane_bits = 4'b1111;
    endcase
    span      = {12'b0, lane_bits} << port[2:0];
    mask_lo   = span[7:0];
    mask_hi   = span[15:8];
    spans_two = |span[15:8];
    off_first = BMO_W'(port >> 3);
    off_last  = off_first + BMO_W'(spans_two);
  end
endmodule

// File: rtl/pio_merge.sv
module pio_merge
  import pio_pkg::*;
#(
  parameter int ACC_W = 64,
  parameter int IO_DW = 32
) (
  input  logic [ACC_W-1:0] acc_old,
  input  logic [IO_DW-1:0] rdata,
  input  io_size_t         size,
  input  logic             wide64,
  output logic [ACC_W-1:0] acc_new
);
  localparam int HI_W = ACC_W - IO_DW;

  always_comb begin
    acc_new = acc_old;
    case (size)
      SZ_BYTE: acc_new[7:0]  = rdata[7:0];
      SZ_WORD: acc_new[15:0] = rdata[15:0];
      default: begin
        acc_new[IO_DW-1:0] = rdata;
        if (wide64) acc_new[ACC_W-1:IO_DW] = {HI_W{1'b0}};
      end
    endcase
  end
endmodule

// File: rtl/pio_read_unit.sv
module pio_read_unit
  import pio_pkg::*;
#(
  parameter int PORT_W = 16,
  parameter int ACC_W = 64,
  parameter int IO_DW = 32,
  localparam int BMO_W = PORT_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ins_valid,
  output logic              ins_ready,
  input  logic [7:0]        ins_opcode,
  input  logic [7:0]        ins_imm,
  input  logic [PORT_W-1:0] ins_dx,
  input  logic [1:0]        ins_osize,
  input  logic [1:0]        ins_cpl,
  input  logic [1:0]        ins_iopl,
  input  logic              ins_vm,
  input  logic [ACC_W-1:0]  acc_in,
  input  logic [BMO_W-1:0]  bm_limit,
  output logic              bm_req,
  output logic [BMO_W-1:0]  bm_addr,
  input  logic              bm_ack,
  input  logic [7:0]        bm_data,
  output logic              io_req,
  output logic [PORT_W-1:0] io_addr,
  output logic [1:0]        io_size,
  input  logic              io_ack,
  input  logic [IO_DW-1:0]  io_rdata,
  output logic              done,
  output logic              fault,
  output logic [ACC_W-1:0]  acc_out
);
  pio_state_t st;

  logic              d_bad, d_need, d_two;
  logic [PORT_W-1:0] d_port;
  io_size_t          d_size;
  logic [BMO_W-1:0]  d_first, d_last;
  logic [7:0]        d_mlo, d_mhi;

  logic [PORT_W-1:0] port_q;
  io_size_t          size_q;
  logic              wide64_q, two_q, idx_q;
  logic [BMO_W-1:0]  first_q;
  logic [7:0]        mlo_q, mhi_q;
  logic [ACC_W-1:0]  acc_q, acc_merged;
  logic              deny;

  pio_decode #(.PORT_W(PORT_W), .BMO_W(BMO_W)) u_dec (
    .opcode(ins_opcode), .imm(ins_imm), .dx(ins_dx), .osize(ins_osize),
    .cpl(ins_cpl), .iopl(ins_iopl), .vm(ins_vm),
    .bad_op(d_bad), .port(d_port), .size(d_size), .need_chk(d_need),
    .off_first(d_first), .off_last(d_last),
    .mask_lo(d_mlo), .mask_hi(d_mhi), .spans_two(d_two)
  );

  pio_merge #(.ACC_W(ACC_W), .IO_DW(IO_DW)) u_merge (
    .acc_old(acc_q), .rdata(io_rdata), .size(size_q),
    .wide64(wide64_q), .acc_new(acc_merged)
  );

  assign deny = |(bm_data & (idx_q ? mhi_q : mlo_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      port_q   <= '0;
      size_q   <= SZ_BYTE;
      wide64_q <= 1'b0;
      two_q    <= 1'b0;
      idx_q    <= 1'b0;
      first_q  <= '0;
      mlo_q    <= '0;
      mhi_q    <= '0;
      acc_q    <= '0;
    end else begin
      case (st)
        ST_IDLE: if (ins_valid) begin
          port_q   <= d_port;
          size_q   <= d_size;
          wide64_q <= ins_osize == OSZ_64;
          two_q    <= d_two;
          idx_q    <= 1'b0;
          first_q  <= d_first;
          mlo_q    <= d_mlo;
          mhi_q    <= d_mhi;
          acc_q    <= acc_in;
          if (d_bad)                     st <= ST_FLT;
          else if (!d_need)              st <= ST_BUS;
          else if (d_last > bm_limit)    st <= ST_FLT;
          else                           st <= ST_BMAP;
        end
        ST_BMAP: if (bm_ack) begin
          if (deny)                      st <= ST_FLT;
          else if (idx_q || !two_q)      st <= ST_BUS;
          else                           idx_q <= 1'b1;
        end
        ST_BUS: if (io_ack) begin
          acc_q <= acc_merged;
          st    <= ST_DONE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ins_ready = st == ST_IDLE;
    bm_req    = st == ST_BMAP;
    bm_addr   = first_q + BMO_W'(idx_q);
    io_req    = st == ST_BUS;
    io_addr   = port_q;
    io_size   = size_q;
    done      = (st == ST_DONE) || (st == ST_FLT);
    fault     = st == ST_FLT;
    acc_out   = acc_q;
  end
endmodule

// File: rtl/pio_read_unit_chk.sv
module pio_read_unit_chk #(
  parameter int PORT_W = 16,
  parameter int BMO_W = PORT_W - 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ins_valid,
  input logic              ins_ready,
  input logic              op_dx,
  input logic              op_wide,
  input logic [7:0]        ins_imm,
  input logic [PORT_W-1:0] ins_dx,
  input logic [1:0]        ins_cpl,
  input logic [1:0]        ins_iopl,
  input logic              ins_vm,
  input logic              bm_req,
  input logic [BMO_W-1:0]  bm_addr,
  input logic              bm_ack,
  input logic              io_req,
  input logic [PORT_W-1:0] io_addr,
  input logic [1:0]        io_size,
  input logic              io_ack,
  input logic              done,
  input logic              fault
);
  logic              need_q, wide_q;
  logic [PORT_W-1:0] exp_port_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      need_q     <= 1'b0;
      wide_q     <= 1'b0;
      exp_port_q <= '0;
    end else if (ins_valid && ins_ready) begin
      need_q     <= (ins_cpl > ins_iopl) || ins_vm;
      wide_q     <= op_wide;
      exp_port_q <= op_dx ? ins_dx : PORT_W'(ins_imm);
    end
  end

  p_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    io_req |-> io_addr == exp_port_q);
  p_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
    io_req |-> ((io_size == 2'd0) == !wide_q) && io_size != 2'd3);
  p_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bm_req |-> need_q);
  p_bm_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bm_req && !bm_ack |=> bm_req && $stable(bm_addr));
  p_io_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    io_req && !io_ack |=> io_req && $stable(io_addr) && $stable(io_size));
  p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_req && bm_req));
  p_fault_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> done);
  p_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_ready_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ins_ready |-> !io_req && !bm_req && !done);
endmodule

bind pio_read_unit pio_read_unit_chk #(.PORT_W(PORT_W), .BMO_W(BMO_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_ready(ins_ready),
  .op_dx(ins_opcode[3]), .op_wide(ins_opcode[0]), .ins_imm(ins_imm),
  .ins_dx(ins_dx), .ins_cpl(ins_cpl), .ins_iopl(ins_iopl), .ins_vm(ins_vm),
  .bm_req(bm_req), .bm_addr(bm_addr), .bm_ack(bm_ack), .io_req(io_req),
  .io_addr(io_addr), .io_size(io_size), .io_ack(io_ack), .done(done),
  .fault(fault)
);

// File: tb/pio_read_unit_test.sv
module pio_read_unit_test;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, ins_valid, ins_ready, ins_vm;
  logic [7:0]  ins_opcode, ins_imm, bm_data;
  logic [15:0] ins_dx, io_addr;
  logic [1:0]  ins_osize, ins_cpl, ins_iopl, io_size;
  logic [63:0] acc_in, acc_out;
  logic [13:0] bm_limit, bm_addr;
  logic        bm_req, bm_ack, io_req, io_ack, done, fault;
  logic [31:0] io_rdata;

  pio_read_unit uut (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_ready(ins_ready),
    .ins_opcode(ins_opcode), .ins_imm(ins_imm), .ins_dx(ins_dx),
    .ins_osize(ins_osize), .ins_cpl(ins_cpl), .ins_iopl(ins_iopl),
    .ins_vm(ins_vm), .acc_in(acc_in), .bm_limit(bm_limit), .bm_req(bm_req),
    .bm_addr(bm_addr), .bm_ack(bm_ack), .bm_data(bm_data), .io_req(io_req),
    .io_addr(io_addr), .io_size(io_size), .io_ack(io_ack),
    .io_rdata(io_rdata), .done(done), .fault(fault), .acc_out(acc_out)
  );

  int checks = 0, errors = 0;
  int bm_cnt, io_cnt;
  logic [13:0] bm_seen0, bm_seen1;
  logic [15:0] io_seen_addr;
  logic [1:0]  io_seen_size;
  logic [7:0]  bm_key, bm_keep;
  logic [31:0] io_word;

  function automatic logic [7:0] bmval(logic [13:0] off);
    return ((off[7:0] * 8'h3B) ^ {2'b0, off[13:8]} ^ bm_key) & bm_keep;
  endfunction

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  initial begin
    bm_ack = 1'b0; bm_data = 8'h0;
    forever begin
      @(negedge clk);
      bm_ack = 1'b0;
      if (bm_req) begin
        int lat;
        lat = $urandom % 3;
        repeat (lat) @(negedge clk);
        bm_data = bmval(bm_addr);
        if (bm_cnt == 0) bm_seen0 = bm_addr; else bm_seen1 = bm_addr;
        bm_cnt++;
        bm_ack = 1'b1;
      end
    end
  end

  initial begin
    io_ack = 1'b0; io_rdata = 32'h0;
    forever begin
      @(negedge clk);
      io_ack = 1'b0;
      if (io_req) begin
        int lat;
        lat = $urandom % 3;
        repeat (lat) @(negedge clk);
        io_rdata = io_word;
        io_seen_addr = io_addr;
        io_seen_size = io_size;
        io_cnt++;
        io_ack = 1'b1;
      end
    end
  end

  task automatic run(logic [7:0] op, logic [7:0] imm, logic [15:0] dx,
                     logic [1:0] osz, logic [1:0] cpl, logic [1:0] iopl,
                     logic vm, logic [63:0] acc, logic [13:0] lim);
    int p, n, f0, fl, reads, wait_n;
    bit bad, need, deny, exp_fault;
    logic [63:0] exp_acc;
    logic [7:0] b;
    string tag;
    bad  = !(op == 8'hE4 || op == 8'hE5 || op == 8'hEC || op == 8'hED);
    p    = op[3] ? int'(dx) : int'(imm);
    n    = !op[0] ? 1 : (osz == 2'd0 ? 2 : 4);
    need = (cpl > iopl) || vm;
    f0   = p / 8;
    fl   = (p + n - 1) / 8;
    reads = 0; deny = 0; exp_fault = 0; tag = "R3";
    if (bad) begin
      exp_fault = 1; tag = "R11";
    end else if (need && fl > int'(lim)) begin
      exp_fault = 1; tag = "R6";
    end else if (need) begin
      tag = "R4";
      for (int off = f0; off <= fl && !deny; off++) begin
        reads++;
        b = bmval(14'(off));
        for (int i = 0; i < n; i++)
          if ((p + i) / 8 == off && b[(p + i) % 8]) deny = 1;
      end
      if (deny) begin exp_fault = 1; tag = "R5"; end
    end
    case (n)
      1: exp_acc = {acc[63:8], io_word[7:0]};
      2: exp_acc = {acc[63:16], io_word[15:0]};
      default: exp_acc = (osz == 2'd2) ? {32'h0, io_word} : {acc[63:32], io_word};
    endcase

    @(negedge clk);
    bm_cnt = 0; io_cnt = 0;
    ins_opcode = op; ins_imm = imm; ins_dx = dx; ins_osize = osz;
    ins_cpl = cpl; ins_iopl = iopl; ins_vm = vm; acc_in = acc; bm_limit = lim;
    ins_valid = 1'b1;
    @(negedge clk);
    ins_valid = 1'b0;
    chk("R9", "ready low after accept", 64'(ins_ready), 64'd0);
    wait_n = 0;
    while (!done && wait_n < 100) begin
      @(negedge clk);
      wait_n++;
    end
    chk("R9", "done seen", 64'(done), 64'd1);
    chk(tag, "fault", 64'(fault), 64'(exp_fault));
    chk(tag, "bitmap reads", 64'(bm_cnt), 64'(reads));
    if (reads >= 1) chk("R4", "first offset", 64'(bm_seen0), 64'(f0));
    if (reads == 2) chk("R4", "second offset", 64'(bm_seen1), 64'(f0 + 1));
    chk(exp_fault ? tag : "R3", "bus reads", 64'(io_cnt), exp_fault ? 64'd0 : 64'd1);
    if (!exp_fault) begin
      chk("R1", "port", 64'(io_seen_addr), 64'(p));
      chk("R2", "size code", 64'(io_seen_size), n == 1 ? 64'd0 : (n == 2 ? 64'd1 : 64'd2));
      chk(n == 4 ? "R8" : "R7", "accumulator", acc_out, exp_acc);
    end
    @(negedge clk);
    chk("R9", "done single cycle", 64'(done), 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] ops [4];
    ops = '{8'hE4, 8'hE5, 8'hEC, 8'hED};
    void'($urandom(32'd4242));
    rst_n = 1'b0; ins_valid = 1'b0; ins_opcode = 8'h0; ins_imm = 8'h0;
    ins_dx = 16'h0; ins_osize = 2'd0; ins_cpl = 2'd0; ins_iopl = 2'd0;
    ins_vm = 1'b0; acc_in = 64'h0; bm_limit = 14'h0;
    bm_key = 8'h0; bm_keep = 8'h0; io_word = 32'h0;
    bm_cnt = 0; io_cnt = 0;
    repeat (3) @(negedge clk);
    chk("R9", "reset ready", 64'(ins_ready), 64'd1);
    chk("R9", "reset done", 64'(done), 64'd0);
    chk("R10", "reset requests", 64'({bm_req, io_req}), 64'd0);
    rst_n = 1'b1;

    // directed corners
    io_word = 32'hA1B2C3D4; bm_keep = 8'h00; bm_key = 8'h00;
    run(8'hE4, 8'h7F, 16'h1234, 2'd1, 2'd0, 2'd3, 1'b0, 64'h1122334455667788, 14'h3FFF);
    run(8'hED, 8'h00, 16'hBEEF, 2'd2, 2'd0, 2'd0, 1'b0, 64'hFFFFFFFFFFFFFFFF, 14'h3FFF);
    run(8'hED, 8'h00, 16'hBEEF, 2'd1, 2'd0, 2'd0, 1'b0, 64'hFFFFFFFFFFFFFFFF, 14'h3FFF);
    run(8'hE5, 8'hFF, 16'h0000, 2'd0, 2'd3, 2'd0, 1'b0, 64'h0123456789ABCDEF, 14'h3FFF);
    run(8'hED, 8'h00, 16'hFFFF, 2'd1, 2'd0, 2'd0, 1'b1, 64'h0, 14'h1FFF);
    run(8'hED, 8'h00, 16'hFFFF, 2'd1, 2'd0, 2'd0, 1'b1, 64'h0, 14'h2000);
    bm_keep = 8'hFF; bm_key = 8'h5A;
    run(8'hEC, 8'h00, 16'h0040, 2'd0, 2'd3, 2'd1, 1'b0, 64'h0, 14'h3FFF);
    run(8'hEC, 8'h00, 16'h0040, 2'd0, 2'd1, 2'd1, 1'b0, 64'h0, 14'h3FFF);
    run(8'h90, 8'h00, 16'h0040, 2'd0, 2'd0, 2'd0, 1'b0, 64'h0, 14'h3FFF);

    for (int k = 0; k < 300; k++) begin
      logic [7:0] op;
      op = ($urandom % 16 == 0) ? 8'($urandom) : ops[$urandom % 4];
      io_word = $urandom;
      bm_key  = 8'($urandom);
      case ($urandom % 3)
        0: bm_keep = 8'h00;
        1: bm_keep = 8'h11;
        default: bm_keep = 8'($urandom);
      endcase
      run(op, 8'($urandom), 16'($urandom), 2'($urandom % 3), 2'($urandom),
          2'($urandom), ($urandom % 4) == 0, {$urandom, $urandom},
          ($urandom % 5 == 0) ? 14'($urandom) : 14'h3FFF);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule